// File: doc/BRIEF.md
# Trap Entry and Return Controller

This block sequences trap entry and trap return for a 32-bit processor core with a circular set of register windows. It owns the program counter pair (PC and NPC), the trap base register, the window pointer and the three status flags that a trap touches: supervisor, previous supervisor and trap enable. Three request streams feed it, each with a valid/ready handshake:
- hardware trap requests, each carrying an 8-bit trap type;
- software trap instructions, each carrying two operands;
- trap-return instructions, each carrying two operands.

A plain control side lets the pipeline advance the PC pair, mark the next instruction as annulled and write the trap base register.

On a vectored trap the block computes a vector from the base register and the trap type. It redirects the PC pair to that vector, saves supervisor state, disables traps and rotates the window pointer down by one. It then sends two register-file write requests on an outgoing valid/ready stream that save the old PC and the old NPC into the new window. While either save beat is still pending, no request stream is ready. A stalled consumer therefore holds back every later trap or return, and no save can be lost or reordered.

A software trap that arrives while traps are disabled does not vector. It puts the block into a sticky error mode that freezes all state. On the request side, ready for a lower-priority stream drops whenever a higher-priority stream is valid. A request is taken on a clock edge where both its valid and its ready are high. On the save stream, a beat is held stable until the consumer raises ready.

Top module: `trap_seq_ctrl`

## Requirements
- R1: A vectored trap with type T sets PC to {TBR[31:12], T, 4'b0000} and NPC to that value plus 4. It loads the same full 32-bit vector into the trap base register and clears the annul flag. All of these are visible on the clock edge after acceptance.
- R2: A vectored trap clears the trap-enable flag, copies the old supervisor flag into the previous-supervisor flag, and sets the supervisor flag to 1.
- R3: A vectored trap moves the window pointer to (CWP - 1) mod NWIN. A trap return moves it to (CWP + 1) mod NWIN. The window count NWIN is a parameter from 2 to 32.
- R4: After a vectored trap the save stream presents two beats, in this order:
  - local register index 1 (sav_idx = 3'd1) carrying the old PC;
  - local register index 2 (sav_idx = 3'd2) carrying the old NPC.

  Both beats target the new window pointer. A beat stays valid and unchanged while sav_ready is low.
- R5: A software trap uses trap type 128 + bits 6:0 of (sw_op_a + sw_op_b).
- R6: An ordinary trap-base write (tbr_wr_en) changes only bits 31:12 of the trap base register. Bits 11:0 keep their value.
- R7: A software trap accepted while trap enable is 0 sets error_mode, which stays set until reset. In that case the PC pair, the flags, the window pointer and the base register are unchanged, no save beats appear, and trap_taken stays low. While error_mode is 1 every request ready is low, and step, annul_set and tbr_wr_en have no effect.
- R8: A trap return copies previous-supervisor into supervisor and sets trap enable. It moves NPC into PC and loads NPC with ret_op_a + ret_op_b.
- R9: Requests are ranked hardware, then software, then return:
  - hw_ready = not error_mode and no save beat pending;
  - sw_ready = hw_ready and not hw_valid;
  - ret_ready = sw_ready and not sw_valid.
- R10: trap_taken is high for exactly the one cycle after a vectored trap is accepted. It stays low after a return or after an error-mode entry.
- R11: After reset:
  - PC = 0 and NPC = 4;
  - supervisor = 1, previous supervisor = 0 and trap enable = 0;
  - the window pointer and the trap base register are 0;
  - annul, error_mode, trap_taken and sav_valid are 0.
- R12: With no request accepted in a cycle, step moves NPC into PC, adds 4 to NPC and clears annul, and annul_set (without step) sets annul. In a cycle where a trap or return is accepted, step, annul_set and tbr_wr_en have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_valid | input | 1 | Hardware trap request valid |
| hw_ready | output | 1 | Hardware trap request ready |
| hw_type | input | 8 | Hardware trap type |
| sw_valid | input | 1 | Software trap instruction valid |
| sw_ready | output | 1 | Software trap instruction ready |
| sw_op_a | input | 32 | Software trap first operand |
| sw_op_b | input | 32 | Software trap second operand |
| ret_valid | input | 1 | Trap return valid |
| ret_ready | output | 1 | Trap return ready |
| ret_op_a | input | 32 | Return target first operand |
| ret_op_b | input | 32 | Return target second operand |
| step | input | 1 | Advance the PC pair by one instruction |
| annul_set | input | 1 | Mark the next instruction annulled |
| tbr_wr_en | input | 1 | Ordinary trap-base write enable |
| tbr_wr_data | input | 32 | Trap-base write data (bits 31:12 used) |
| sav_valid | output | 1 | Save write valid |
| sav_ready | input | 1 | Save write ready |
| sav_win | output | $clog2(NWIN) | Window receiving the save write |
| sav_idx | output | 3 | Local register index (1 or 2) |
| sav_data | output | 32 | Value to write |
| pc | output | 32 | Current PC |
| npc | output | 32 | Current NPC |
| tbr | output | 32 | Trap base register |
| psr_s | output | 1 | Supervisor flag |
| psr_ps | output | 1 | Previous-supervisor flag |
| psr_et | output | 1 | Trap-enable flag |
| cwp | output | $clog2(NWIN) | Current window pointer |
| annul | output | 1 | Annul flag |
| trap_taken | output | 1 | One-cycle vectored-trap pulse |
| error_mode | output | 1 | Sticky error-mode flag |

## Verification
The bench uses a five-window configuration, so that window arithmetic that only works for power-of-two counts fails to wrap from 0 to 4. It sweeps all 256 hardware trap types, each with a different base register value, so a misplaced type field or leaking low base bits shows up as a wrong PC. A software trap sweep uses operand sums that carry past bit 6, which catches a design that takes the type from only one operand or from the wrong bits. Targeted cases cover the following:
- Simultaneous requests, where a broken priority takes the wrong trap.
- A stalled save consumer, where a design could reorder or drop the PC/NPC beats or accept a new trap.
- step and base writes in a trap cycle, where a careless design would corrupt the vector.
- A software trap with traps disabled, which must freeze the state instead of vectoring.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

  localparam int XLEN    = 32;
  localparam int TT_W    = 8;
  localparam int TT_LSB  = 4;
  localparam int BASE_LSB = TT_LSB + TT_W;
  localparam int SW_BITS = 7;

  localparam logic [2:0] LREG_OLD_PC  = 3'd1;
  localparam logic [2:0] LREG_OLD_NPC = 3'd2;

  typedef struct packed {
    logic sup;
    logic prev_sup;
    logic en;
  } flags_t;

  function automatic logic [TT_W-1:0] sw_trap_type(input logic [SW_BITS-1:0] low);
    return {1'b1, low};
  endfunction

endpackage

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
  import trap_seq_pkg::*;
(
  input  logic [XLEN-BASE_LSB-1:0] base_hi,
  input  logic [TT_W-1:0]          tt,
  output logic [XLEN-1:0]          vec,
  output logic [XLEN-1:0]          vec_next
);
  assign vec      = {base_hi, tt, {TT_LSB{1'b0}}};
  assign vec_next = vec + XLEN'(4);
endmodule

// File: rtl/trap_window_arith.sv
module trap_window_arith #(
  parameter int NWIN = 8,
  localparam int CW  = $clog2(NWIN)
) (
  input  logic [CW-1:0] cur,
  output logic [CW-1:0] dec,
  output logic [CW-1:0] inc
);
  localparam logic [CW-1:0] LAST = CW'(NWIN - 1);

  generate
    if ((1 << CW) == NWIN) begin : g_pow2
      assign dec = cur - 1'b1;
      assign inc = cur + 1'b1;
    end else begin : g_odd
      assign dec = (cur == '0)   ? LAST : cur - 1'b1;
      assign inc = (cur == LAST) ? '0   : cur + 1'b1;
    end
  endgenerate

  initial begin
    a_r3_nwin_range: assert (NWIN >= 2 && NWIN <= 32);
  end
endmodule

// File: rtl/trap_save_queue.sv
module trap_save_queue
  import trap_seq_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CW-1:0]   load_win,
  input  logic [XLEN-1:0] load_pc,
  input  logic [XLEN-1:0] load_npc,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [CW-1:0]   out_win,
  output logic [2:0]      out_idx,
  output logic [XLEN-1:0] out_data,
  output logic            busy
);
  logic [1:0]      left;
  logic [XLEN-1:0] held_pc, held_npc;
  logic [CW-1:0]   held_win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left     <= 2'd0;
      held_pc  <= '0;
      held_npc <= '0;
      held_win <= '0;
    end else if (load) begin
      left     <= 2'd2;
      held_pc  <= load_pc;
      held_npc <= load_npc;
      held_win <= load_win;
    end else if (out_valid && out_ready) begin
      left <= left - 2'd1;
    end
  end

  assign out_valid = (left != 2'd0);
  assign out_win   = held_win;
  assign out_idx   = (left == 2'd2) ? LREG_OLD_PC : LREG_OLD_NPC;
  assign out_data  = (left == 2'd2) ? held_pc : held_npc;
  assign busy      = out_valid;

  // R4: a stalled beat stays put
  a_r4_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_idx) && $stable(out_win)));
  // R4: old-PC beat is followed by the old-NPC beat
  a_r4_beat_order: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_idx == LREG_OLD_PC) |=> (out_valid && out_idx == LREG_OLD_NPC));
  // R9: never reloaded while beats are pending
  a_r9_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
endmodule

// File: rtl/trap_seq_ctrl.sv
module trap_seq_ctrl
  import trap_seq_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int CW  = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hw_valid,
  output logic            hw_ready,
  input  logic [7:0]      hw_type,
  input  logic            sw_valid,
  output logic            sw_ready,
  input  logic [31:0]     sw_op_a,
  input  logic [31:0]     sw_op_b,
  input  logic            ret_valid,
  output logic            ret_ready,
  input  logic [31:0]     ret_op_a,
  input  logic [31:0]     ret_op_b,
  input  logic            step,
  input  logic            annul_set,
  input  logic            tbr_wr_en,
  input  logic [31:0]     tbr_wr_data,
  output logic            sav_valid,
  input  logic            sav_ready,
  output logic [CW-1:0]   sav_win,
  output logic [2:0]      sav_idx,
  output logic [31:0]     sav_data,
  output logic [31:0]     pc,
  output logic [31:0]     npc,
  output logic [31:0]     tbr,
  output logic            psr_s,
  output logic            psr_ps,
  output logic            psr_et,
  output logic [CW-1:0]   cwp,
  output logic            annul,
  output logic            trap_taken,
  output logic            error_mode
);
  localparam logic [CW-1:0] LAST_WIN = CW'(NWIN - 1);

  flags_t          flags;
  logic            save_busy;
  logic            hw_fire, sw_fire, ret_fire;
  logic            sw_vec_fire, sw_err_fire, vec_fire;
  logic [XLEN-1:0] sw_sum, ret_sum;
  logic [TT_W-1:0] sel_tt;
  logic [XLEN-1:0] vec, vec_next;
  logic [CW-1:0]   cwp_dec, cwp_inc;
  logic            in_unused;

  // request arbitration: hardware > software > return
  assign hw_ready  = !error_mode && !save_busy;
  assign sw_ready  = hw_ready && !hw_valid;
  assign ret_ready = sw_ready && !sw_valid;

  assign hw_fire     = hw_valid && hw_ready;
  assign sw_fire     = sw_valid && sw_ready;
  assign ret_fire    = ret_valid && ret_ready;
  assign sw_vec_fire = sw_fire && flags.en;
  assign sw_err_fire = sw_fire && !flags.en;
  assign vec_fire    = hw_fire || sw_vec_fire;

  assign sw_sum  = sw_op_a + sw_op_b;
  assign ret_sum = ret_op_a + ret_op_b;
  assign sel_tt  = hw_fire ? hw_type : sw_trap_type(sw_sum[SW_BITS-1:0]);
  assign in_unused = ^{sw_sum[XLEN-1:SW_BITS], tbr_wr_data[BASE_LSB-1:0]};

  trap_vector_gen u_vec (
    .base_hi  (tbr[XLEN-1:BASE_LSB]),
    .tt       (sel_tt),
    .vec      (vec),
    .vec_next (vec_next)
  );

  trap_window_arith #(.NWIN(NWIN)) u_win (
    .cur (cwp),
    .dec (cwp_dec),
    .inc (cwp_inc)
  );

  trap_save_queue #(.CW(CW)) u_save (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (vec_fire),
    .load_win  (cwp_dec),
    .load_pc   (pc),
    .load_npc  (npc),
    .out_valid (sav_valid),
    .out_ready (sav_ready),
    .out_win   (sav_win),
    .out_idx   (sav_idx),
    .out_data  (sav_data),
    .busy      (save_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc         <= '0;
      npc        <= XLEN'(4);
      tbr        <= '0;
      flags      <= '{sup: 1'b1, prev_sup: 1'b0, en: 1'b0};
      cwp        <= '0;
      annul      <= 1'b0;
      trap_taken <= 1'b0;
      error_mode <= 1'b0;
    end else begin
      trap_taken <= 1'b0;
      if (vec_fire) begin
        pc             <= vec;
        npc            <= vec_next;
        tbr            <= vec;
        flags.en       <= 1'b0;
        flags.prev_sup <= flags.sup;
        flags.sup      <= 1'b1;
        cwp            <= cwp_dec;
        annul          <= 1'b0;
        trap_taken     <= 1'b1;
      end else if (sw_err_fire) begin
        error_mode <= 1'b1;
      end else if (ret_fire) begin
        flags.sup <= flags.prev_sup;
        flags.en  <= 1'b1;
        cwp       <= cwp_inc;
        pc        <= npc;
        npc       <= ret_sum;
      end else if (!error_mode) begin
        if (tbr_wr_en)
          tbr[XLEN-1:BASE_LSB] <= tbr_wr_data[XLEN-1:BASE_LSB];
        if (step) begin
          pc    <= npc;
          npc   <= npc + XLEN'(4);
          annul <= 1'b0;
        end else if (annul_set) begin
          annul <= 1'b1;
        end
      end
    end
  end

  assign psr_s  = flags.sup;
  assign psr_ps = flags.prev_sup;
  assign psr_et = flags.en;

  // R1: vector is aligned to 16 bytes and NPC follows it
  a_r1_vector_shape: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fire |=> (pc[3:0] == 4'h0 && npc == pc + 32'd4 && tbr == pc && !annul));
  // R1: base bits survive trap entry
  a_r1_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fire |=> tbr[31:12] == $past(tbr[31:12]));
  // R2: supervisor state on entry
  a_r2_entry_flags: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fire |=> (psr_s && !psr_et && psr_ps == $past(psr_s)));
  // R3: entry rotates the window down with wrap
  a_r3_entry_window: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fire |=> cwp == (($past(cwp) == '0) ? LAST_WIN : $past(cwp) - 1'b1));
  // R3: return rotates the window up with wrap
  a_r3_return_window: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |=> cwp == (($past(cwp) == LAST_WIN) ? '0 : $past(cwp) + 1'b1));
  // R5: software vector carries a type of at least 128
  a_r5_sw_type_high: assert property (@(posedge clk) disable iff (!rst_n)
    sw_vec_fire |=> tbr[11]);
  // R7: error mode is sticky and freezes the PC
  a_r7_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    error_mode |=> (error_mode && $stable(pc) && $stable(npc) && $stable(cwp)));
  // R8: return re-enables traps and restores supervisor
  a_r8_return_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |=> (psr_et && psr_s == $past(psr_ps) && pc == $past(npc)));
  // R9: at most one request stream accepted per cycle
  a_r9_one_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hw_fire, sw_fire, ret_fire}));
  // R10: the trap pulse lasts one cycle
  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |=> !trap_taken);
endmodule

// File: tb/sim_trap_seq_ctrl.sv
module sim_trap_seq_ctrl;
  localparam int NW = 5;
  localparam int CW = $clog2(NW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_valid = 0, sw_valid = 0, ret_valid = 0;
  logic hw_ready, sw_ready, ret_ready;
  logic [7:0] hw_type = '0;
  logic [31:0] sw_op_a = '0, sw_op_b = '0, ret_op_a = '0, ret_op_b = '0;
  logic step = 0, annul_set = 0, tbr_wr_en = 0;
  logic [31:0] tbr_wr_data = '0;
  logic sav_valid, sav_ready = 1'b1;
  logic [CW-1:0] sav_win, cwp;
  logic [2:0] sav_idx;
  logic [31:0] sav_data, pc, npc, tbr;
  logic psr_s, psr_ps, psr_et, annul, trap_taken, error_mode;

  always #10 clk = ~clk;

  trap_seq_ctrl #(.NWIN(NW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .hw_valid(hw_valid), .hw_ready(hw_ready), .hw_type(hw_type),
    .sw_valid(sw_valid), .sw_ready(sw_ready), .sw_op_a(sw_op_a), .sw_op_b(sw_op_b),
    .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_op_a(ret_op_a), .ret_op_b(ret_op_b),
    .step(step), .annul_set(annul_set), .tbr_wr_en(tbr_wr_en), .tbr_wr_data(tbr_wr_data),
    .sav_valid(sav_valid), .sav_ready(sav_ready), .sav_win(sav_win), .sav_idx(sav_idx),
    .sav_data(sav_data), .pc(pc), .npc(npc), .tbr(tbr), .psr_s(psr_s), .psr_ps(psr_ps),
    .psr_et(psr_et), .cwp(cwp), .annul(annul), .trap_taken(trap_taken), .error_mode(error_mode)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_pc, m_npc, m_tbr;
  logic m_s, m_ps, m_et, m_annul, m_err;
  int m_cwp;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    chk({tag, " pc"}, pc, m_pc);
    chk({tag, " npc"}, npc, m_npc);
    chk({tag, " tbr"}, tbr, m_tbr);
    chk({tag, " s"}, psr_s, m_s);
    chk({tag, " ps"}, psr_ps, m_ps);
    chk({tag, " et"}, psr_et, m_et);
    chk({tag, " cwp"}, cwp, m_cwp);
    chk({tag, " annul"}, annul, m_annul);
    chk({tag, " error_mode"}, error_mode, m_err);
  endtask

  task automatic model_entry(input logic [7:0] tt);
    m_tbr   = {m_tbr[31:12], tt, 4'h0};
    m_pc    = m_tbr;
    m_npc   = m_tbr + 32'd4;
    m_ps    = m_s;
    m_s     = 1'b1;
    m_et    = 1'b0;
    m_cwp   = (m_cwp + NW - 1) % NW;
    m_annul = 1'b0;
  endtask

  // called at the first negedge after the accepting edge
  task automatic expect_saves(input logic [31:0] opc, input logic [31:0] onpc, input int hold);
    chk("R10 trap_taken pulse", trap_taken, 1);
    for (int k = 0; k < hold; k++) begin
      chk("R4 stalled valid", sav_valid, 1);
      chk("R4 stalled idx", sav_idx, 3'd1);
      chk("R4 stalled data", sav_data, opc);
      chk("R9 hw_ready low while pending", hw_ready, 0);
      @(negedge clk);
    end
    sav_ready = 1'b1;
    chk("R4 beat1 valid", sav_valid, 1);
    chk("R4 beat1 idx", sav_idx, 3'd1);
    chk("R4 beat1 data old pc", sav_data, opc);
    chk("R4 beat1 window", sav_win, m_cwp);
    @(negedge clk);
    chk("R10 trap_taken one cycle", trap_taken, 0);
    chk("R4 beat2 valid", sav_valid, 1);
    chk("R4 beat2 idx", sav_idx, 3'd2);
    chk("R4 beat2 data old npc", sav_data, onpc);
    chk("R4 beat2 window", sav_win, m_cwp);
    @(negedge clk);
    chk("R4 drained", sav_valid, 0);
    chk("R9 hw_ready after drain", hw_ready, 1);
  endtask

  task automatic do_hw(input logic [7:0] tt, input bit noise, input int hold);
    logic [31:0] opc, onpc;
    opc = m_pc; onpc = m_npc;
    @(negedge clk);
    hw_valid = 1; hw_type = tt;
    if (hold > 0) sav_ready = 1'b0;
    if (noise) begin step = 1; annul_set = 1; tbr_wr_en = 1; tbr_wr_data = 32'hFFFF_FFFF; end
    #1 chk("R9 hw_ready", hw_ready, 1);
    @(negedge clk);
    hw_valid = 0; step = 0; annul_set = 0; tbr_wr_en = 0;
    model_entry(tt);
    check_state(noise ? "R12 R1 R2 R3 hw trap with noise" : "R1 R2 R3 hw trap");
    expect_saves(opc, onpc, hold);
  endtask

  task automatic do_sw(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] opc, onpc, sum;
    opc = m_pc; onpc = m_npc; sum = a + b;
    @(negedge clk);
    sw_valid = 1; sw_op_a = a; sw_op_b = b;
    #1 chk("R9 sw_ready", sw_ready, 1);
    @(negedge clk);
    sw_valid = 0;
    model_entry({1'b1, sum[6:0]});
    check_state("R5 R1 sw trap");
    expect_saves(opc, onpc, 0);
  endtask

  task automatic do_ret(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    ret_valid = 1; ret_op_a = a; ret_op_b = b;
    #1 chk("R9 ret_ready", ret_ready, 1);
    @(negedge clk);
    ret_valid = 0;
    m_s = m_ps; m_et = 1; m_cwp = (m_cwp + 1) % NW;
    m_pc = m_npc; m_npc = a + b;
    check_state("R8 R3 return");
    chk("R10 no pulse on return", trap_taken, 0);
    chk("R4 no save on return", sav_valid, 0);
  endtask

  task automatic do_step();
    @(negedge clk); step = 1;
    @(negedge clk); step = 0;
    m_pc = m_npc; m_npc = m_npc + 32'd4; m_annul = 0;
    check_state("R12 step");
  endtask

  task automatic do_tbr_wr(input logic [31:0] d);
    @(negedge clk); tbr_wr_en = 1; tbr_wr_data = d;
    @(negedge clk); tbr_wr_en = 0;
    m_tbr = {d[31:12], m_tbr[11:0]};
    check_state("R6 tbr write");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_pc = 0; m_npc = 4; m_tbr = 0; m_s = 1; m_ps = 0; m_et = 0;
    m_cwp = 0; m_annul = 0; m_err = 0;
    #1 check_state("R11 reset");
    chk("R11 reset trap_taken", trap_taken, 0);
    chk("R11 reset sav_valid", sav_valid, 0);

    // all hardware trap types, alternating entry/return, windows wrap 0<->4
    for (int i = 0; i < 256; i++) begin
      do_tbr_wr((i * 32'h0133_7000) ^ 32'hA5A5_5A5A);
      do_step();
      do_hw(8'(i), 1'b0, 0);
      do_ret(32'(i) << 2, 32'h0000_1000);
    end

    // software trap sweep, sums carry past bit 6 (et is 1 here)
    for (int i = 0; i < 128; i++) begin
      do_sw(32'(i * 7 + 3), 32'hFFFF_FF00 + 32'(i * 13));
      do_ret(32'h4000, 32'(i) << 3);
    end

    // nested hardware traps walk the window down twice, trap with et=0 still vectors
    do_hw(8'h11, 1'b0, 0);
    do_hw(8'h22, 1'b0, 0);
    do_ret(32'h100, 32'h0);
    do_ret(32'h200, 32'h0);

    // annul set, then cleared by trap entry
    @(negedge clk); annul_set = 1;
    @(negedge clk); annul_set = 0; m_annul = 1;
    check_state("R12 annul set");
    do_hw(8'h05, 1'b0, 0);
    do_ret(32'h300, 32'h0);

    // noise in the trap cycle is ignored
    do_hw(8'h3C, 1'b1, 0);
    do_ret(32'h400, 32'h0);

    // back-pressure on the save stream
    do_hw(8'h47, 1'b0, 3);
    do_ret(32'h500, 32'h0);

    // priority: hw beats sw in the same cycle
    begin
      logic [31:0] opc, onpc;
      opc = m_pc; onpc = m_npc;
      @(negedge clk);
      hw_valid = 1; hw_type = 8'h09; sw_valid = 1; sw_op_a = 1; sw_op_b = 2;
      #1 chk("R9 sw_ready low under hw", sw_ready, 0);
      chk("R9 ret_ready low under hw", ret_ready, 0);
      @(negedge clk);
      hw_valid = 0; sw_valid = 0;
      model_entry(8'h09);
      check_state("R9 hw wins");
      expect_saves(opc, onpc, 0);
    end
    do_ret(32'h600, 32'h0);

    // priority: sw beats return
    begin
      logic [31:0] opc, onpc;
      opc = m_pc; onpc = m_npc;
      @(negedge clk);
      sw_valid = 1; sw_op_a = 32'h7F; sw_op_b = 32'h3; ret_valid = 1; ret_op_a = 0; ret_op_b = 0;
      #1 chk("R9 ret_ready low under sw", ret_ready, 0);
      @(negedge clk);
      sw_valid = 0; ret_valid = 0;
      model_entry(8'h82);
      check_state("R9 R5 sw wins");
      expect_saves(opc, onpc, 0);
    end

    // software trap with traps disabled -> error mode
    @(negedge clk);
    sw_valid = 1; sw_op_a = 32'h10; sw_op_b = 32'h20;
    @(negedge clk);
    sw_valid = 0;
    m_err = 1;
    check_state("R7 error entry");
    chk("R7 no pulse", trap_taken, 0);
    chk("R7 no save", sav_valid, 0);
    @(negedge clk);
    hw_valid = 1; ret_valid = 1; step = 1; tbr_wr_en = 1; tbr_wr_data = 32'hDEAD_B000; annul_set = 1;
    #1 chk("R7 hw_ready low", hw_ready, 0);
    chk("R7 ret_ready low", ret_ready, 0);
    @(negedge clk);
    hw_valid = 0; ret_valid = 0; step = 0; tbr_wr_en = 0; annul_set = 0;
    check_state("R7 frozen");
    chk("R7 still no save", sav_valid, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule